// File: doc/BRIEF.md
# Stokes Scale-Offset Requantizer

This block sits in front of a spectral vector accumulator. It conditions the polarization products of each frequency channel. Each input beat carries one wide signed integer sample and a tag naming which of the four Stokes products (I, Q, U, V) it holds. The block adds a per-product offset, multiplies by a per-product gain, then rounds and saturates the result to a signed 8-bit word. Because every product has its own coefficient pair, software can steer the useful bits of each product into the narrow output window on its own terms.

A mode setting selects one of two readouts. Full Stokes keeps all four products. Total intensity keeps only I and Q: it still accepts U and V beats but discards them. Coefficients and mode are written through a simple register write port into shadow storage. The shadow values are copied into the working set when the first beat of a channel (an I beat) is accepted, so one channel never mixes two coefficient sets.

Both data interfaces use valid/ready. On input, a beat transfers on a clock edge where `in_valid` and `in_ready` are both high. On output, a beat transfers where `out_valid` and `out_ready` are both high. While the output holds a beat that is not taken, the whole pipeline freezes: `in_ready` is low and the output beat stays unchanged. When `out_ready` is held high, the block never back-pressures.

Top module: `stokes_requant`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every gain starts at 1.0, every offset starts at 0, and the mode starts at full Stokes.
- R2: For a kept beat with integer sample x, the result is (x + offset) × gain. The offset is signed with 16 fractional bits and the gain is unsigned with 16 fractional bits, both 32 bits wide.
- R3: The result is rounded to the nearest integer, with exact halves rounded upward (toward +infinity).
- R4: A rounded value above 127 is output as 127, and one below -128 is output as -128.
- R5: The tag codes are 0=I, 1=Q, 2=U, 3=V. Each tag uses its own coefficients. Gains are at write addresses 0..3 and offsets at addresses 4..7, both in tag order.
- R6: Write address 8 sets the mode: any nonzero value selects full Stokes and zero selects total intensity. In total intensity, beats tagged U or V are accepted but produce no output beat.
- R7: A coefficient or mode write takes effect only when the next I-tagged beat is accepted after the write cycle. That I beat and the rest of its channel use the new values. Beats accepted before it use the old values.
- R8: With `out_ready` held high, a kept beat accepted at a clock edge appears on the output after exactly 3 clock edges. Its tag is carried unchanged to `out_tag`.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_tag` stay stable. No beat is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_tag | input | 2 | Stokes product of the input beat (0=I,1=Q,2=U,3=V) |
| in_data | input | DW (24) | Signed integer sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0..3 gain, 4..7 offset, 8 mode) |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_tag | output | 2 | Stokes product of the output beat |
| out_data | output | OW (8) | Signed requantized value |

## Verification
Each kept beat shows up on the output three edges after the edge that accepts it, unless the output stalls. A dedicated check counts the falling edges after an acceptance and requires `out_valid` on the third and not before. All other results are collected by a monitor that records a beat at the falling edge whenever valid and ready are both high. Each check then waits with a bounded timeout for the next recorded beat, so stalls and latency never shift which value is compared. Effects of writes (commit at an I beat, dropped U/V beats) are judged by the order and number of recorded beats. During a forced stall, the held output and the low `in_ready` are sampled several cycles apart before release.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic [1:0] {
    TAG_I = 2'd0,
    TAG_Q = 2'd1,
    TAG_U = 2'd2,
    TAG_V = 2'd3
  } stokes_tag_e;

  localparam int NPROD      = 4;
  localparam int CW         = 32;   // coefficient width
  localparam int FRAC       = 16;   // fractional bits of each coefficient
  localparam logic [3:0] ADDR_OFF_BASE = 4'd4;
  localparam logic [3:0] ADDR_MODE     = 4'd8;
  localparam logic [CW-1:0] GAIN_ONE   = 32'h0001_0000;
endpackage

// File: rtl/stq_coef_bank.sv
module stq_coef_bank
  import stq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          commit,
  input  logic [1:0]    sel_tag,
  output logic [CW-1:0] eff_gain,
  output logic [CW-1:0] eff_off,
  output logic          eff_full
);
  logic [NPROD-1:0][CW-1:0] sh_gain, sh_off, wk_gain, wk_off;
  logic                     sh_full, wk_full;

  for (genvar g = 0; g < NPROD; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_gain[g] <= GAIN_ONE;
        sh_off[g]  <= '0;
        wk_gain[g] <= GAIN_ONE;
        wk_off[g]  <= '0;
      end else begin
        if (cfg_we && cfg_addr == 4'(g))
          sh_gain[g] <= cfg_wdata;
        if (cfg_we && cfg_addr == ADDR_OFF_BASE + 4'(g))
          sh_off[g] <= cfg_wdata;
        if (commit) begin
          wk_gain[g] <= sh_gain[g];
          wk_off[g]  <= sh_off[g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_full <= 1'b1;
      wk_full <= 1'b1;
    end else begin
      if (cfg_we && cfg_addr == ADDR_MODE)
        sh_full <= (cfg_wdata != '0);
      if (commit)
        wk_full <= sh_full;
    end
  end

  // The committing beat already sees the shadow set.
  always_comb begin
    eff_gain = commit ? sh_gain[sel_tag] : wk_gain[sel_tag];
    eff_off  = commit ? sh_off[sel_tag]  : wk_off[sel_tag];
    eff_full = commit ? sh_full : wk_full;
  end

  // R7
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(wk_gain) && $stable(wk_off) && $stable(wk_full)));
endmodule

// File: rtl/stq_offset_stage.sv
module stq_offset_stage
  import stq_pkg::*;
#(
  parameter int DW = 24,
  parameter int SW = 41
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 v_in,
  input  logic [1:0]           tag_in,
  input  logic [DW-1:0]        x_in,
  input  logic [CW-1:0]        off_in,
  input  logic [CW-1:0]        gain_in,
  output logic                 v_out,
  output logic [1:0]           tag_out,
  output logic signed [SW-1:0] sum_out,
  output logic [CW-1:0]        gain_out
);
  logic signed [SW-1:0] x_ext, off_ext;
  assign x_ext   = {{(SW-DW-FRAC){x_in[DW-1]}}, x_in, {FRAC{1'b0}}};
  assign off_ext = {{(SW-CW){off_in[CW-1]}}, off_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
    end else if (advance) begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      tag_out  <= tag_in;
      sum_out  <= x_ext + off_ext;
      gain_out <= gain_in;
    end
  end
endmodule

// File: rtl/stq_mul_stage.sv
module stq_mul_stage
  import stq_pkg::*;
#(
  parameter int SW = 41,
  parameter int PW = 74
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 v_in,
  input  logic [1:0]           tag_in,
  input  logic signed [SW-1:0] sum_in,
  input  logic [CW-1:0]        gain_in,
  output logic                 v_out,
  output logic [1:0]           tag_out,
  output logic signed [PW-1:0] prod_out
);
  logic signed [CW:0] gain_s;
  assign gain_s = $signed({1'b0, gain_in});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
    end else if (advance) begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      tag_out  <= tag_in;
      prod_out <= sum_in * gain_s;
    end
  end
endmodule

// File: rtl/stq_round_sat_stage.sv
module stq_round_sat_stage
  import stq_pkg::*;
#(
  parameter int PW = 74,
  parameter int OW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 v_in,
  input  logic [1:0]           tag_in,
  input  logic signed [PW-1:0] prod_in,
  output logic                 v_out,
  output logic [1:0]           tag_out,
  output logic [OW-1:0]        q_out
);
  localparam int SH = 2 * FRAC;

  logic signed [PW-1:0] half, rnd, shifted, maxv, minv;
  logic [OW-1:0]        sat;

  assign half    = {{(PW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
  assign maxv    = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  assign minv    = {{(PW-OW+1){1'b1}}, {(OW-1){1'b0}}};
  assign rnd     = prod_in + half;
  assign shifted = rnd >>> SH;

  always_comb begin
    if (shifted > maxv)      sat = maxv[OW-1:0];
    else if (shifted < minv) sat = minv[OW-1:0];
    else                     sat = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
    end else if (advance) begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      tag_out <= tag_in;
      q_out   <= sat;
    end
  end
endmodule

// File: rtl/stokes_requant.sv
module stokes_requant
  import stq_pkg::*;
#(
  parameter int DW = 24,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_tag,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_tag,
  output logic [OW-1:0] out_data
);
  localparam int SWA = DW + FRAC + 1;
  localparam int SW  = (SWA > CW + 1) ? SWA : CW + 1;
  localparam int PW  = SW + CW + 1;

  logic          advance, accept, commit, keep;
  logic [CW-1:0] eff_gain, eff_off;
  logic          eff_full;

  logic                 s1_valid, s2_valid;
  logic [1:0]           s1_tag, s2_tag;
  logic signed [SW-1:0] s1_sum;
  logic [CW-1:0]        s1_gain;
  logic signed [PW-1:0] s2_prod;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;
  assign commit   = accept && (in_tag == TAG_I);
  assign keep     = !in_tag[1] || eff_full;

  stq_coef_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .commit    (commit),
    .sel_tag   (in_tag),
    .eff_gain  (eff_gain),
    .eff_off   (eff_off),
    .eff_full  (eff_full)
  );

  stq_offset_stage #(.DW(DW), .SW(SW)) u_s1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .v_in     (accept && keep),
    .tag_in   (in_tag),
    .x_in     (in_data),
    .off_in   (eff_off),
    .gain_in  (eff_gain),
    .v_out    (s1_valid),
    .tag_out  (s1_tag),
    .sum_out  (s1_sum),
    .gain_out (s1_gain)
  );

  stq_mul_stage #(.SW(SW), .PW(PW)) u_s2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .v_in     (s1_valid),
    .tag_in   (s1_tag),
    .sum_in   (s1_sum),
    .gain_in  (s1_gain),
    .v_out    (s2_valid),
    .tag_out  (s2_tag),
    .prod_out (s2_prod)
  );

  stq_round_sat_stage #(.PW(PW), .OW(OW)) u_s3 (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .v_in    (s2_valid),
    .tag_in  (s2_tag),
    .prod_in (s2_prod),
    .v_out   (out_valid),
    .tag_out (out_tag),
    .q_out   (out_data)
  );

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_tag[1] && !eff_full) |=> !s1_valid);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(accept && keep, 3) && $past(advance, 2) && $past(advance, 1))
      |-> out_valid);
endmodule

// File: tb/tb_stokes_requant.sv
module tb_stokes_requant;
  localparam int DW = 24;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_tag = '0;
  logic [DW-1:0] in_data = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_tag;
  logic [OW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stokes_requant #(.DW(DW), .OW(OW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_data(out_data)
  );

  logic [9:0] got_q[$];  // {tag, data}

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got_q.push_back({out_tag, out_data});

  typedef struct packed {
    logic [31:0]       g;
    logic [31:0]       o;
    logic signed [23:0] x;
    logic signed [7:0]  e;
  } vec_t;

  // R2 R3 R4: I-product gain/offset/sample/expected
  localparam vec_t TBL [13] = '{
    '{32'h0001_0000, 32'h0000_0000,  24'sd5,      8'sd5},
    '{32'h0001_0000, 32'h0000_0000, -24'sd7,     -8'sd7},
    '{32'h0001_0000, 32'h0000_0000,  24'sd200,    8'sd127},
    '{32'h0001_0000, 32'h0000_0000, -24'sd200,   -8'sd128},
    '{32'h0000_8000, 32'h0000_0000,  24'sd3,      8'sd2},
    '{32'h0000_8000, 32'h0000_0000, -24'sd3,     -8'sd1},
    '{32'h0002_0000, 32'h0003_0000,  24'sd10,     8'sd26},
    '{32'h0000_4000, 32'hFFFF_8000,  24'sd100,    8'sd25},
    '{32'h0000_0000, 32'h0000_0000,  24'sd1000,   8'sd0},
    '{32'h0010_0000, 32'h0000_0000,  24'sd8,      8'sd127},
    '{32'h0000_0100, 32'h0000_0000, -24'sd32768, -8'sd128},
    '{32'h0000_0100, 32'h0000_0000,  24'sd32640,  8'sd127},
    '{32'h0000_0100, 32'h0000_0000, -24'sd32640, -8'sd127}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input int x);
    @(negedge clk);
    cfg_we   = 1'b0;
    in_valid = 1'b1;
    in_tag   = t;
    in_data  = DW'(x);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_beat(input string req, input logic [1:0] t, input int v);
    int n = 0;
    logic [9:0] b;
    while (got_q.size() == 0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    if (got_q.size() == 0) begin
      check(req, -999, v);
    end else begin
      b = got_q.pop_front();
      check({req, " tag"}, int'(b[9:8]), int'(t));
      check(req, int'($signed(b[7:0])), v);
    end
  endtask

  task automatic expect_none(input string req);
    repeat (12) @(negedge clk);
    check(req, got_q.size(), 0);
    got_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and default coefficients
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    send(2'd0, 42);
    send(2'd1, -3);
    idle();
    expect_beat("R1 default I", 2'd0, 42);
    expect_beat("R1 default Q", 2'd1, -3);

    // R8: exact latency
    send(2'd0, 1);
    begin
      int lat = 0;
      for (int k = 1; k <= 5; k++) begin
        idle();
        if (out_valid && lat == 0) lat = k;
      end
      check("R8 latency", lat, 3);
    end
    got_q.delete();

    // R2 R3 R4: vector table
    foreach (TBL[i]) begin
      wr(4'd0, TBL[i].g);
      wr(4'd4, TBL[i].o);
      send(2'd0, int'(TBL[i].x));
      idle();
      expect_beat($sformatf("R2/R3/R4 vec%0d", i), 2'd0, int'(TBL[i].e));
    end

    // R5: independent coefficients per product
    wr(4'd0, 32'h0001_0000); wr(4'd1, 32'h0002_0000);
    wr(4'd2, 32'h0003_0000); wr(4'd3, 32'h0000_8000);
    wr(4'd4, 32'h0000_0000); wr(4'd5, 32'h0001_0000);
    wr(4'd6, 32'hFFFF_0000); wr(4'd7, 32'h0002_0000);
    send(2'd0, 10); send(2'd1, 10); send(2'd2, 10); send(2'd3, 10);
    idle();
    expect_beat("R5 I", 2'd0, 10);
    expect_beat("R5 Q", 2'd1, 22);
    expect_beat("R5 U", 2'd2, 27);
    expect_beat("R5 V", 2'd3, 6);

    // R7: mid-channel write waits for the next I beat
    send(2'd0, 10);
    wr(4'd1, 32'h0001_0000);
    send(2'd1, 10);
    idle();
    expect_beat("R7 I", 2'd0, 10);
    expect_beat("R7 Q old gain", 2'd1, 22);
    send(2'd0, 10); send(2'd1, 10);
    idle();
    expect_beat("R7 I next", 2'd0, 10);
    expect_beat("R7 Q new gain", 2'd1, 11);

    // R6: total intensity drops U and V
    wr(4'd8, 32'd0);
    send(2'd0, 4); send(2'd1, 4); send(2'd2, 4); send(2'd3, 4);
    idle();
    expect_beat("R6 I", 2'd0, 4);
    expect_beat("R6 Q", 2'd1, 5);
    expect_none("R6 U/V dropped");

    // R7: mode write inside a channel keeps the old mode
    send(2'd0, 4);
    wr(4'd8, 32'd1);
    send(2'd1, 4); send(2'd2, 4);
    idle();
    expect_beat("R7 mode I", 2'd0, 4);
    expect_beat("R7 mode Q", 2'd1, 5);
    expect_none("R7 mode U still dropped");
    send(2'd0, 4); send(2'd1, 4); send(2'd2, 4); send(2'd3, 4);
    idle();
    expect_beat("R6 full I", 2'd0, 4);
    expect_beat("R6 full Q", 2'd1, 5);
    expect_beat("R6 full U", 2'd2, 9);
    expect_beat("R6 full V", 2'd3, 3);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    fork
      begin
        send(2'd0, 4); send(2'd1, 4); send(2'd2, 4); send(2'd3, 4);
        idle();
      end
      begin
        logic [7:0] held;
        repeat (8) @(negedge clk);
        check("R9 out_valid held", int'(out_valid), 1);
        check("R9 in_ready low", int'(in_ready), 0);
        held = out_data;
        repeat (4) @(negedge clk);
        check("R9 data stable", int'(out_data), int'(held));
        check("R9 nothing taken", got_q.size(), 0);
        out_ready = 1'b1;
      end
    join
    expect_beat("R9 I", 2'd0, 4);
    expect_beat("R9 Q", 2'd1, 5);
    expect_beat("R9 U", 2'd2, 9);
    expect_beat("R9 V", 2'd3, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule